// File: doc/BRIEF.md
# Two-Stage System Watchdog

This block watches that software is still alive. Once software enables it, a counter advances on every pulse of a fixed-rate timebase input. Software must strobe the block before the count reaches the selected deadline. If it misses the deadline, the block escalates in up to two steps. The first step is a one-clock non-maskable interrupt request. The second step is a system reset request, which is held for a fixed number of clocks. Each step has its own enable.

A 3-bit selector picks one of eight deadlines. Measured in quarter-second units they are 1, 2, 4, 8, 16, 64, 256 and 1024, so the deadline runs from 0.25 s to 256 s. The parameter `UNIT_TICKS` sets how many timebase pulses make up one quarter second. A cause flag records that the watchdog issued the last reset. Only the power-up reset clears this flag. The ordinary system reset, including the reset the watchdog itself requests, leaves it unchanged.

The controller has four named states:
- `WD_OFF` is idle.
- `WD_STAGE1` counts the first deadline.
- `WD_STAGE2` counts the second deadline, after the interrupt.
- `WD_RESET` holds the reset request.

The transitions are:
- `WD_OFF` goes to `WD_STAGE1` when enabled, with the count restarted.
- `WD_STAGE1` goes to `WD_STAGE2` on expiry when both steps are enabled.
- `WD_STAGE1` goes to `WD_RESET` on expiry when only reset is enabled.
- `WD_STAGE1` stays in `WD_STAGE1`, with the count restarted, on expiry when only the interrupt or neither step is enabled, and on a strobe or a selector change.
- `WD_STAGE2` goes back to `WD_STAGE1` on a strobe.
- `WD_STAGE2` goes to `WD_RESET` on expiry.
- `WD_STAGE1` and `WD_STAGE2` go to `WD_OFF` when the block is disabled.
- `WD_RESET` goes to `WD_OFF` after the hold time.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-up reset, `nmi_pulse`, `rst_req` and `wd_caused_rst` are all 0.
- R2: While `cfg_en` is 0, or while both `cfg_nmi_en` and `cfg_rst_en` are 0, no interrupt pulse and no reset request is ever produced.
- R3: The deadline is `U(cfg_sel)*UNIT_TICKS` timebase ticks, where U for selector values 0 to 7 is 1, 2, 4, 8, 16, 64, 256 and 1024. With a tick on every clock, the first expiry output appears L clocks after the clock edge that arms the count.
- R4: A one-clock `strobe` restarts the count, so the next expiry comes a full deadline after that strobe.
- R5: With only the interrupt enabled, each expiry produces a `nmi_pulse` that is exactly one clock wide. The count then restarts, so the pulses repeat every deadline.
- R6: With both steps enabled, the first expiry gives the interrupt, and the reset request rises one full deadline later. A strobe in between cancels the reset and returns the block to first-step counting.
- R7: With only reset enabled, the first expiry raises `rst_req` directly, and no interrupt pulse is produced.
- R8: `rst_req` stays high for exactly `RST_HOLD` clocks and is then released.
- R9: `wd_caused_rst` is set in the same cycle that `rst_req` rises. A `rst_n` pulse leaves it unchanged, and only `por_n` clears it.
- R10: Enabling the block, or changing `cfg_sel` while it counts, restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low; does not clear the cause flag |
| por_n | input | 1 | Power-up reset, active low; clears everything |
| tick | input | 1 | Fixed-rate timebase pulse |
| cfg_en | input | 1 | Watchdog enable |
| cfg_nmi_en | input | 1 | Enable for the first step (interrupt) |
| cfg_rst_en | input | 1 | Enable for the second step (reset) |
| cfg_sel | input | 3 | Deadline selector |
| strobe | input | 1 | Software keep-alive pulse |
| nmi_pulse | output | 1 | One-clock non-maskable interrupt request |
| rst_req | output | 1 | System reset request, held RST_HOLD clocks |
| wd_caused_rst | output | 1 | Sticky flag: the watchdog issued the last reset |

## Verification
Every selector value is timed to the exact clock, so an error in the deadline table or an off-by-one count shows up as a pulse one cycle early or late.

A switch from the longest deadline to the shortest, made in the middle of a count, targets a design that does not restart on a selector change. Such a design would either expire at once or run far past the new deadline. A strobe placed between the interrupt and the reset targets a design that still issues the reset.

The reset-only case targets a design that leaks an interrupt. The measured width of the reset request targets an off-by-one hold counter. The `rst_n` and `por_n` pulses show whether the cause flag is wiped by the wrong reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_STAGE1,
        WD_STAGE2,
        WD_RESET
    } wd_state_e;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned N_PERIODS = 1 << SEL_W;
    localparam int unsigned MAX_UNITS = 1024;

    // Deadline length in quarter-second units for each selector value.
    function automatic int unsigned wd_units(input int unsigned sel);
        case (sel)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 8;
            4:       return 16;
            5:       return 64;
            6:       return 256;
            default: return MAX_UNITS;
        endcase
    endfunction

endpackage

// File: rtl/wdog_period_lut.sv
module wdog_period_lut
    import wdog_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 250,
    parameter int unsigned CW         = 18
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CW-1:0]    limit
);

    logic [CW-1:0] tbl [N_PERIODS];

    // One table entry per selector value: the deadline in ticks.
    for (genvar i = 0; i < N_PERIODS; i++) begin : g_entry
        assign tbl[i] = CW'(wd_units(i) * UNIT_TICKS);
    end

    assign limit = tbl[sel];

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int unsigned CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Expiry fires on the tick that would complete the deadline.
    assign expire = run && tick && (cnt == limit - CW'(1));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned RST_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic nmi_en,
    input  logic rst_en,
    input  logic strobe,
    input  logic sel_chg,
    input  logic expire,
    output logic run,
    output logic restart,
    output logic enter_rst,
    output logic nmi_pulse,
    output logic rst_req
);

    localparam int unsigned HW = $clog2(RST_HOLD + 1);

    wd_state_e     state, nxt;
    logic [HW-1:0] hold_cnt;
    logic          hold_done;
    logic          nmi_fire;

    assign hold_done = (hold_cnt == HW'(RST_HOLD - 1));

    // State register and the reset hold counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= WD_OFF;
            hold_cnt <= '0;
        end else begin
            state    <= nxt;
            hold_cnt <= (state == WD_RESET) ? hold_cnt + HW'(1) : '0;
        end
    end

    always_comb begin
        nxt       = state;
        restart   = 1'b0;
        nmi_fire  = 1'b0;
        enter_rst = 1'b0;
        unique case (state)
            WD_OFF: begin
                if (en) begin
                    nxt     = WD_STAGE1;
                    restart = 1'b1;
                end
            end
            WD_STAGE1: begin
                if (!en) begin
                    nxt = WD_OFF;
                end else if (strobe || sel_chg) begin
                    restart = 1'b1;
                end else if (expire) begin
                    restart  = 1'b1;
                    nmi_fire = nmi_en;
                    if (rst_en && nmi_en) begin
                        nxt = WD_STAGE2;
                    end else if (rst_en) begin
                        nxt       = WD_RESET;
                        enter_rst = 1'b1;
                    end
                end
            end
            WD_STAGE2: begin
                if (!en) begin
                    nxt = WD_OFF;
                end else if (strobe) begin
                    nxt     = WD_STAGE1;
                    restart = 1'b1;
                end else if (sel_chg) begin
                    restart = 1'b1;
                end else if (expire) begin
                    restart = 1'b1;
                    if (rst_en) begin
                        nxt       = WD_RESET;
                        enter_rst = 1'b1;
                    end else begin
                        nxt = WD_STAGE1;
                    end
                end
            end
            WD_RESET: begin
                if (hold_done) begin
                    nxt = WD_OFF;
                end
            end
        endcase
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pulse <= 1'b0;
        end else begin
            nmi_pulse <= nmi_fire;
        end
    end

    assign rst_req = (state == WD_RESET);
    assign run     = (state == WD_STAGE1) || (state == WD_STAGE2);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 250,
    parameter int unsigned RST_HOLD   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             tick,
    input  logic             cfg_en,
    input  logic             cfg_nmi_en,
    input  logic             cfg_rst_en,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             strobe,
    output logic             nmi_pulse,
    output logic             rst_req,
    output logic             wd_caused_rst
);

    localparam int unsigned CW = $clog2(MAX_UNITS * UNIT_TICKS + 1);

    logic             sys_rst_n;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;
    logic [CW-1:0]    limit;
    logic             run, restart, expire, enter_rst;

    assign sys_rst_n = rst_n & por_n;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= cfg_sel;
        end
    end

    assign sel_chg = (cfg_sel != sel_q);

    // The cause flag is cleared only by the power-up reset.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wd_caused_rst <= 1'b0;
        end else if (enter_rst) begin
            wd_caused_rst <= 1'b1;
        end
    end

    wdog_period_lut #(.UNIT_TICKS(UNIT_TICKS), .CW(CW)) u_lut (
        .sel   (cfg_sel),
        .limit (limit)
    );

    wdog_tick_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .expire  (expire)
    );

    wdog_fsm #(.RST_HOLD(RST_HOLD)) u_fsm (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .en        (cfg_en),
        .nmi_en    (cfg_nmi_en),
        .rst_en    (cfg_rst_en),
        .strobe    (strobe),
        .sel_chg   (sel_chg),
        .expire    (expire),
        .run       (run),
        .restart   (restart),
        .enter_rst (enter_rst),
        .nmi_pulse (nmi_pulse),
        .rst_req   (rst_req)
    );

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
    parameter int unsigned RST_HOLD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic por_n,
    input logic cfg_en,
    input logic cfg_nmi_en,
    input logic cfg_rst_en,
    input logic nmi_pulse,
    input logic rst_req,
    input logic wd_caused_rst
);

    localparam int unsigned RW = $clog2(RST_HOLD + 1) + 1;

    // Clocks that rst_req has already been high in the current run.
    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_len <= '0;
        end else if (!rst_n) begin
            run_len <= '0;
        end else if (rst_req) begin
            run_len <= run_len + RW'(1);
        end else begin
            run_len <= '0;
        end
    end

    a_r2_off_no_nmi: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !cfg_en |=> !nmi_pulse);

    a_r7_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !cfg_nmi_en |=> !nmi_pulse);

    a_r6_rst_needs_en: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(rst_req) |-> $past(cfg_rst_en));

    a_r8_hold_max: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> (run_len < RW'(RST_HOLD)));

    a_r8_hold_len: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $fell(rst_req) |-> (run_len == RW'(RST_HOLD)));

    a_r9_flag_with_rst: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> wd_caused_rst);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        wd_caused_rst |=> wd_caused_rst);

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .cfg_en        (cfg_en),
    .cfg_nmi_en    (cfg_nmi_en),
    .cfg_rst_en    (cfg_rst_en),
    .nmi_pulse     (nmi_pulse),
    .rst_req       (rst_req),
    .wd_caused_rst (wd_caused_rst)
);

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;

    localparam int UT   = 2;
    localparam int HOLD = 16;
    localparam int UNITS [8] = '{1, 2, 4, 8, 16, 64, 256, 1024};

    typedef struct {
        int    kind;   // 0 = interrupt pulse, 1 = reset request rise
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0, tick = 1'b1;
    logic       en = 1'b0, nmi_en = 1'b0, rst_en = 1'b0, strobe = 1'b0;
    logic [2:0] sel = '0;
    logic       nmi_pulse, rst_req, wd_caused_rst;

    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    int   nmi_seen = 0, rst_seen = 0, hold_run = 0;
    logic rst_prev = 1'b0;
    bit   finished = 1'b0;
    exp_t expq [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_two_stage #(.UNIT_TICKS(UT), .RST_HOLD(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
        .cfg_en(en), .cfg_nmi_en(nmi_en), .cfg_rst_en(rst_en),
        .cfg_sel(sel), .strobe(strobe),
        .nmi_pulse(nmi_pulse), .rst_req(rst_req), .wd_caused_rst(wd_caused_rst)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(int kind, int c, string req);
        exp_t e;
        e.kind = kind; e.cyc = c; e.req = req;
        expq.push_back(e);
    endtask

    task automatic got(int kind);
        exp_t e;
        if (expq.size() == 0) begin
            chk(1'b0, kind == 0 ? "R2 unexpected nmi" : "R2 unexpected rst", cyc, -1);
        end else begin
            e = expq.pop_front();
            chk(e.kind == kind, {e.req, " kind"}, kind, e.kind);
            chk(e.cyc == cyc, {e.req, " cycle"}, cyc, e.cyc);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (por_n && rst_n) begin
            if (nmi_pulse) begin
                nmi_seen++;
                got(0);
            end
            if (rst_req && !rst_prev) begin
                rst_seen++;
                hold_run = 0;
                got(1);
            end
            if (rst_req) hold_run++;
            if (!rst_req && rst_prev) chk(hold_run == HOLD, "R8 hold length", hold_run, HOLD);
        end
        rst_prev = rst_req;
    end

    task automatic wn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(logic [2:0] s, bit ne, bit re, output int c0);
        sel = s; nmi_en = ne; rst_en = re; en = 1'b1;
        c0 = cyc;
    endtask

    task automatic kick(output int cs);
        strobe = 1'b1;
        cs = cyc;
        wn(1);
        strobe = 1'b0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        chk(1'b0, "watchdog timeout", 0, 1);
        finish_up();
    end

    initial begin
        int c0, cs, L, ns, rs;
        wn(3);
        por_n = 1'b1; rst_n = 1'b1;
        wn(1);
        // R1: state after power-up
        chk(nmi_pulse == 0, "R1 nmi", nmi_pulse, 0);
        chk(rst_req == 0, "R1 rst", rst_req, 0);
        chk(wd_caused_rst == 0, "R1 flag", wd_caused_rst, 0);

        // R2: disabled, then enabled with both steps off
        ns = nmi_seen; rs = rst_seen;
        sel = 0; nmi_en = 1; rst_en = 1; en = 0;
        wn(40);
        chk(nmi_seen == ns && rst_seen == rs, "R2 disabled quiet", nmi_seen + rst_seen, ns + rs);
        arm(0, 0, 0, c0);
        wn(40);
        en = 0;
        wn(2);
        chk(nmi_seen == ns && rst_seen == rs, "R2 no action enabled", nmi_seen + rst_seen, ns + rs);

        // R3 / R5: every deadline, interrupt only, two pulses each
        for (int s = 0; s < 8; s++) begin
            L = UNITS[s] * UT;
            arm(3'(s), 1, 0, c0);
            push(0, c0 + 1 + L, "R3 first expiry");
            push(0, c0 + 1 + 2 * L, "R5 repeat pulse");
            wn(2 * L + 1);
            en = 0;
            wn(3);
            chk(expq.size() == 0, "R3 pulses seen", expq.size(), 0);
        end

        // R4: strobes keep it alive
        L = UNITS[2] * UT;
        arm(2, 1, 0, c0);
        wn(3);
        for (int k = 0; k < 5; k++) begin
            kick(cs);
            wn(5);
        end
        kick(cs);
        push(0, cs + 1 + L, "R4 after last strobe");
        wn(L + 1);
        en = 0;
        wn(3);
        chk(expq.size() == 0, "R4 pulse seen", expq.size(), 0);

        // R6: both steps, reset one deadline after the interrupt
        L = UNITS[1] * UT;
        arm(1, 1, 1, c0);
        push(0, c0 + 1 + L, "R6 first step");
        push(1, c0 + 1 + 2 * L, "R6 second step");
        wn(2 * L + 3);
        en = 0;
        wn(HOLD + 4);
        chk(expq.size() == 0, "R6 events seen", expq.size(), 0);
        chk(wd_caused_rst == 1, "R9 flag set", wd_caused_rst, 1);

        // R9: system reset keeps the flag, power-up clears it
        rst_n = 0; wn(2); rst_n = 1; wn(1);
        chk(wd_caused_rst == 1, "R9 survives rst_n", wd_caused_rst, 1);
        por_n = 0; wn(2); por_n = 1; wn(1);
        chk(wd_caused_rst == 0, "R9 cleared by por_n", wd_caused_rst, 0);

        // R6: strobe between the steps cancels the reset
        arm(1, 1, 1, c0);
        push(0, c0 + 1 + L, "R6 first step");
        wn(L + 2);
        kick(cs);
        push(0, cs + 1 + L, "R6 restart after strobe");
        wn(L + 1);
        en = 0;
        wn(3);
        chk(expq.size() == 0, "R6 cancel events", expq.size(), 0);
        chk(wd_caused_rst == 0, "R6 no reset after strobe", wd_caused_rst, 0);

        // R7: reset only, no interrupt
        L = UNITS[0] * UT;
        ns = nmi_seen;
        arm(0, 0, 1, c0);
        push(1, c0 + 1 + L, "R7 direct reset");
        wn(L + 3);
        en = 0;
        wn(HOLD + 4);
        chk(nmi_seen == ns, "R7 no nmi", nmi_seen - ns, 0);
        chk(wd_caused_rst == 1, "R9 flag after direct reset", wd_caused_rst, 1);

        // R10: selector change mid-count restarts with the new deadline
        arm(7, 1, 0, c0);
        wn(20);
        sel = 0;
        cs = cyc;
        push(0, cs + 1 + UNITS[0] * UT, "R10 selector change");
        wn(3);
        en = 0;
        wn(4);
        chk(expq.size() == 0, "R10 pulse seen", expq.size(), 0);

        finish_up();
    end

endmodule